// File: doc/BRIEF.md
# Illegal Condition Reset Detector

This block watches the event stream of a small CPU pipeline and asks for a device reset when software does something that cannot be allowed. There are three causes. The first is a fetched instruction whose upper byte holds the reserved illegal code. The second is a working register used as an address pointer before anything has been written to it. The third is a program-counter reload, from a branch or from an interrupt or trap vector, that lands inside a protected code window at an address that is not one of the window's entry slots.

The block keeps one "initialized" bit per working register. The stack-pointer register is the exception: it always counts as initialized. Every bit is cleared at power-on and again whenever the block itself requests a reset. Two protected windows (boot and secure) are described by base and limit inputs. Inside a window only the first few slots on a fixed alignment are legal targets. A request is a one-cycle pulse with a cause code. A single sticky flag records that any illegal condition has happened since power-on.

Top module: `ill_cond_reset`

## Requirements
- R1: When `fetch_valid_i` is high and `fetch_op_hi_i` equals 0x3F, `rst_req_o` is high in the following cycle with `cause_o` = 1. Any other upper-byte value, or 0x3F without `fetch_valid_i`, requests nothing.
- R2: After `rst_n` and after every issued request, registers 0 to 14 count as uninitialized and register 15 (stack pointer) counts as initialized.
- R3: A write to a register marks it initialized from the next cycle onward. A write in the same cycle as a pointer use of that register does not prevent the request.
- R4: A pointer use (`ptr_use_i`) of an uninitialized register gives `rst_req_o` high in the next cycle with `cause_o` = 2.
- R5: A branch reload (`pc_is_vector_i` = 0) whose target lies within [base, limit] of either window gives a request with `cause_o` = 3 unless the target is base + 4*k for k in 0..3. Targets outside every window are legal. A window whose base exceeds its limit is empty.
- R6: A vector reload (`pc_is_vector_i` = 1) is checked against the windows by the same rule as R5 and raises `cause_o` = 3.
- R7: When several causes occur in one cycle, `cause_o` reports opcode (1) over uninitialized pointer (2) over security (3). `cause_o` keeps the last reported cause until the next request or `rst_n`.
- R8: `ill_flag_o` goes high together with the first request and stays high until `rst_n`.
- R9: `rst_req_o` is high only in a cycle that directly follows a cycle with at least one cause.
- R10: A register write in a cycle that raises a request is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| fetch_valid_i | input | 1 | A fetched instruction is present |
| fetch_op_hi_i | input | 8 | Upper byte of the fetched instruction |
| wr_en_i | input | 1 | Working-register write |
| wr_idx_i | input | 4 | Index of the written register |
| ptr_use_i | input | 1 | A register is used as an address pointer |
| ptr_idx_i | input | 4 | Index of the pointer register |
| pc_load_i | input | 1 | Program counter is reloaded |
| pc_is_vector_i | input | 1 | Reload comes from a vector (1) or a branch (0) |
| pc_target_i | input | 16 | Reload target address |
| seg_base_i | input | 32 | Window bases; window 0 (boot) in bits 15:0, window 1 (secure) in 31:16 |
| seg_limit_i | input | 32 | Window limits, same packing as the bases |
| rst_req_o | output | 1 | One-cycle reset request |
| cause_o | output | 2 | Last cause: 0 none, 1 opcode, 2 pointer, 3 security |
| ill_flag_o | output | 1 | Sticky illegal-condition flag |

## Verification
The hardest state to reach from the ports is a register map that a request has cleared while writes were arriving at the same time. The only evidence of it is a later pointer use that should now fail. The vector table therefore chains cycles: it writes a register, triggers a security or opcode request, and then uses the same register as a pointer. It also writes and uses a register in the same cycle that raises the request. All three causes are applied together in one cycle, and then two at a time, to fix the priority order.

// File: rtl/icr_pkg.sv
package icr_pkg;
    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'd0,
        CAUSE_OPCODE = 2'd1,
        CAUSE_UNINIT = 2'd2,
        CAUSE_SECURE = 2'd3
    } cause_e;

    typedef struct packed {
        logic   req;
        cause_e cause;
        logic   flag;
    } icr_state_t;
endpackage

// File: rtl/icr_opc_chk.sv
module icr_opc_chk #(
    parameter int          OPW     = 8,
    parameter logic [7:0]  ILL_OPC = 8'h3F
) (
    input  logic           valid_i,
    input  logic [OPW-1:0] op_i,
    output logic           hit_o
);
    localparam logic [OPW-1:0] ILL_CODE = OPW'(ILL_OPC);

    always_comb begin
        hit_o = valid_i && (op_i == ILL_CODE);
    end
endmodule

// File: rtl/icr_init_map.sv
module icr_init_map #(
    parameter int NREG = 16,
    parameter int IW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [IW-1:0] wr_idx_i,
    input  logic          clr_i,
    input  logic [IW-1:0] rd_idx_i,
    output logic          rd_init_o
);
    localparam int               SP_IDX  = NREG - 1;
    localparam logic [NREG-1:0]  SP_ONLY = {1'b1, {(NREG-1){1'b0}}};

    logic [NREG-1:0] map_d, map_q;

    for (genvar g = 0; g < NREG; g++) begin : g_bit
        if (g == SP_IDX) begin : g_sp
            always_comb map_d[g] = 1'b1;
        end else begin : g_gp
            always_comb begin
                if (clr_i)
                    map_d[g] = 1'b0;
                else
                    map_d[g] = map_q[g] | (wr_en_i && (wr_idx_i == IW'(g)));
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) map_q <= SP_ONLY;
        else        map_q <= map_d;
    end

    always_comb rd_init_o = map_q[rd_idx_i];

    // R2 / R10: a request wipes the map, dropping any write in that cycle
    p_clear_on_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (map_q == SP_ONLY));

    // R3: a write that is not overridden sticks
    p_write_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !clr_i) |=> map_q[$past(wr_idx_i)]);
endmodule

// File: rtl/icr_seg_win.sv
module icr_seg_win #(
    parameter int AW          = 16,
    parameter int ENTRY_SHIFT = 2,
    parameter int NUM_ENTRIES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] base_i,
    input  logic [AW-1:0] limit_i,
    input  logic [AW-1:0] target_i,
    output logic          restricted_o
);
    localparam logic [AW-1:0] ALIGN_MASK = AW'((1 << ENTRY_SHIFT) - 1);
    localparam logic [AW-1:0] SLOT_MAX   = AW'(NUM_ENTRIES);

    logic          in_win;
    logic [AW-1:0] offset;
    logic [AW-1:0] slot;
    logic          entry_ok;

    always_comb begin
        in_win   = (base_i <= limit_i) && (target_i >= base_i) && (target_i <= limit_i);
        offset   = target_i - base_i;
        slot     = offset >> ENTRY_SHIFT;
        entry_ok = ((offset & ALIGN_MASK) == '0) && (slot < SLOT_MAX);
        restricted_o = in_win && !entry_ok;
    end

    // R5: addresses outside the window are never flagged
    p_outside_ok_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((target_i < base_i) || (target_i > limit_i)) |-> !restricted_o);
endmodule

// File: rtl/ill_cond_reset.sv
module ill_cond_reset #(
    parameter int         NREG        = 16,
    parameter int         AW          = 16,
    parameter int         NSEG        = 2,
    parameter int         ENTRY_SHIFT = 2,
    parameter int         NUM_ENTRIES = 4,
    parameter logic [7:0] ILL_OPC     = 8'h3F,
    localparam int        IW          = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fetch_valid_i,
    input  logic [7:0]       fetch_op_hi_i,
    input  logic             wr_en_i,
    input  logic [IW-1:0]    wr_idx_i,
    input  logic             ptr_use_i,
    input  logic [IW-1:0]    ptr_idx_i,
    input  logic             pc_load_i,
    input  logic             pc_is_vector_i,
    input  logic [AW-1:0]    pc_target_i,
    input  logic [NSEG*AW-1:0] seg_base_i,
    input  logic [NSEG*AW-1:0] seg_limit_i,
    output logic             rst_req_o,
    output logic [1:0]       cause_o,
    output logic             ill_flag_o
);
    import icr_pkg::*;

    logic            opc_hit, uninit_hit, sec_hit, any_hit;
    logic            ptr_init;
    logic [NSEG-1:0] seg_restr;
    icr_state_t      st_d, st_q;

    icr_opc_chk #(.OPW(8), .ILL_OPC(ILL_OPC)) u_opc (
        .valid_i (fetch_valid_i),
        .op_i    (fetch_op_hi_i),
        .hit_o   (opc_hit)
    );

    icr_init_map #(.NREG(NREG), .IW(IW)) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_idx_i  (wr_idx_i),
        .clr_i     (any_hit),
        .rd_idx_i  (ptr_idx_i),
        .rd_init_o (ptr_init)
    );

    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        icr_seg_win #(.AW(AW), .ENTRY_SHIFT(ENTRY_SHIFT), .NUM_ENTRIES(NUM_ENTRIES)) u_win (
            .clk          (clk),
            .rst_n        (rst_n),
            .base_i       (seg_base_i[s*AW +: AW]),
            .limit_i      (seg_limit_i[s*AW +: AW]),
            .target_i     (pc_target_i),
            .restricted_o (seg_restr[s])
        );
    end

    // branch and vector reloads share one window check
    always_comb begin
        uninit_hit = ptr_use_i && !ptr_init;
        sec_hit    = pc_load_i && (|seg_restr);
        any_hit    = opc_hit || uninit_hit || sec_hit;

        st_d      = st_q;
        st_d.req  = any_hit;
        st_d.flag = st_q.flag || any_hit;
        if (opc_hit)         st_d.cause = CAUSE_OPCODE;
        else if (uninit_hit) st_d.cause = CAUSE_UNINIT;
        else if (sec_hit)    st_d.cause = CAUSE_SECURE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{req: 1'b0, cause: CAUSE_NONE, flag: 1'b0};
        else        st_q <= st_d;
    end

    assign rst_req_o  = st_q.req;
    assign cause_o    = st_q.cause;
    assign ill_flag_o = st_q.flag;

    // R1: reserved opcode wins and is reported next cycle
    p_opc_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid_i && fetch_op_hi_i == ILL_OPC) |=> (rst_req_o && cause_o == 2'd1));

    // R4 / R7: uninitialized pointer without an opcode fault
    p_uninit_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_use_i && !ptr_init && !opc_hit) |=> (rst_req_o && cause_o == 2'd2));

    // R7: cause holds between requests
    p_cause_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_req_o |-> $stable(cause_o));

    // R8: flag is sticky and accompanies every request
    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ill_flag_o |=> ill_flag_o);
    p_req_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> ill_flag_o);

    // R9: no request without a cause in the prior cycle
    p_req_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !any_hit |=> !rst_req_o);
endmodule

// File: tb/ill_cond_reset_tb_top.sv
`timescale 1ns/1ps
module ill_cond_reset_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_valid_i = 1'b0;
    logic [7:0]  fetch_op_hi_i = '0;
    logic        wr_en_i = 1'b0;
    logic [3:0]  wr_idx_i = '0;
    logic        ptr_use_i = 1'b0;
    logic [3:0]  ptr_idx_i = '0;
    logic        pc_load_i = 1'b0;
    logic        pc_is_vector_i = 1'b0;
    logic [15:0] pc_target_i = '0;
    logic [31:0] seg_base_i  = {16'h0400, 16'h0100};
    logic [31:0] seg_limit_i = {16'h04FF, 16'h01FF};
    logic        rst_req_o;
    logic [1:0]  cause_o;
    logic        ill_flag_o;

    int nchk = 0;
    int nfail = 0;

    always #2 clk = ~clk;

    ill_cond_reset dut_i (
        .clk(clk), .rst_n(rst_n),
        .fetch_valid_i(fetch_valid_i), .fetch_op_hi_i(fetch_op_hi_i),
        .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i),
        .ptr_use_i(ptr_use_i), .ptr_idx_i(ptr_idx_i),
        .pc_load_i(pc_load_i), .pc_is_vector_i(pc_is_vector_i), .pc_target_i(pc_target_i),
        .seg_base_i(seg_base_i), .seg_limit_i(seg_limit_i),
        .rst_req_o(rst_req_o), .cause_o(cause_o), .ill_flag_o(ill_flag_o)
    );

    typedef struct packed {
        logic        fv;  logic [7:0] op;
        logic        we;  logic [3:0] widx;
        logic        pu;  logic [3:0] pidx;
        logic        pl;  logic       pv;  logic [15:0] tgt;
        logic        req; logic [1:0] cause;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{1'b0,8'h00, 1'b0,4'd0, 1'b0,4'd0,  1'b0,1'b0,16'h0000, 1'b0,2'd0, 4'd9},  // 0 R9 idle
        '{1'b1,8'h12, 1'b0,4'd0, 1'b0,4'd0,  1'b0,1'b0,16'h0000, 1'b0,2'd0, 4'd1},  // 1 R1 legal op
        '{1'b0,8'h3F, 1'b0,4'd0, 1'b0,4'd0,  1'b0,1'b0,16'h0000, 1'b0,2'd0, 4'd1},  // 2 R1 not valid
        '{1'b0,8'h00, 1'b0,4'd0, 1'b1,4'd15, 1'b0,1'b0,16'h0000, 1'b0,2'd0, 4'd2},  // 3 R2 sp ok
        '{1'b0,8'h00, 1'b1,4'd3, 1'b0,4'd0,  1'b0,1'b0,16'h0000, 1'b0,2'd0, 4'd3},  // 4 R3 write r3
        '{1'b0,8'h00, 1'b0,4'd0, 1'b1,4'd3,  1'b0,1'b0,16'h0000, 1'b0,2'd0, 4'd3},  // 5 R3 use r3
        '{1'b0,8'h00, 1'b0,4'd0, 1'b0,4'd0,  1'b1,1'b0,16'h0050, 1'b0,2'd0, 4'd5},  // 6 R5 outside
        '{1'b0,8'h00, 1'b0,4'd0, 1'b0,4'd0,  1'b1,1'b0,16'h0104, 1'b0,2'd0, 4'd5},  // 7 R5 entry
        '{1'b0,8'h00, 1'b0,4'd0, 1'b0,4'd0,  1'b1,1'b1,16'h0408, 1'b0,2'd0, 4'd6},  // 8 R6 entry
        '{1'b0,8'h00, 1'b0,4'd0, 1'b0,4'd0,  1'b1,1'b0,16'h0110, 1'b1,2'd3, 4'd5},  // 9 R5 slot 4
        '{1'b0,8'h00, 1'b0,4'd0, 1'b1,4'd3,  1'b0,1'b0,16'h0000, 1'b1,2'd2, 4'd2},  // 10 R2 map wiped
        '{1'b1,8'h3F, 1'b0,4'd0, 1'b0,4'd0,  1'b0,1'b0,16'h0000, 1'b1,2'd1, 4'd1},  // 11 R1
        '{1'b0,8'h00, 1'b0,4'd0, 1'b0,4'd0,  1'b1,1'b1,16'h0401, 1'b1,2'd3, 4'd6},  // 12 R6 misaligned
        '{1'b0,8'h00, 1'b1,4'd5, 1'b1,4'd5,  1'b0,1'b0,16'h0000, 1'b1,2'd2, 4'd3},  // 13 R3 same cycle
        '{1'b0,8'h00, 1'b0,4'd0, 1'b1,4'd5,  1'b0,1'b0,16'h0000, 1'b1,2'd2, 4'd10}, // 14 R10 dropped
        '{1'b0,8'h00, 1'b1,4'd7, 1'b0,4'd0,  1'b0,1'b0,16'h0000, 1'b0,2'd2, 4'd9},  // 15 R9 pulse ends
        '{1'b1,8'h3F, 1'b0,4'd0, 1'b1,4'd0,  1'b1,1'b0,16'h0111, 1'b1,2'd1, 4'd7},  // 16 R7 all three
        '{1'b0,8'h00, 1'b0,4'd0, 1'b1,4'd0,  1'b1,1'b1,16'h0102, 1'b1,2'd2, 4'd7},  // 17 R7 ptr>sec
        '{1'b0,8'h00, 1'b0,4'd0, 1'b0,4'd0,  1'b1,1'b0,16'h0102, 1'b1,2'd3, 4'd5},  // 18 R5
        '{1'b0,8'h00, 1'b0,4'd0, 1'b0,4'd0,  1'b0,1'b0,16'h0000, 1'b0,2'd3, 4'd7},  // 19 R7 hold
        '{1'b0,8'h00, 1'b1,4'd9, 1'b0,4'd0,  1'b0,1'b0,16'h0000, 1'b0,2'd3, 4'd3},  // 20 R3
        '{1'b0,8'h00, 1'b0,4'd0, 1'b1,4'd9,  1'b0,1'b0,16'h0000, 1'b0,2'd3, 4'd3},  // 21 R3
        '{1'b0,8'h00, 1'b0,4'd0, 1'b0,4'd0,  1'b1,1'b0,16'h01FF, 1'b1,2'd3, 4'd5},  // 22 R5 at limit
        '{1'b0,8'h00, 1'b0,4'd0, 1'b0,4'd0,  1'b1,1'b0,16'h0200, 1'b0,2'd3, 4'd5}   // 23 R5 past limit
    };

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        fetch_valid_i = 0; fetch_op_hi_i = 0; wr_en_i = 0; wr_idx_i = 0;
        ptr_use_i = 0; ptr_idx_i = 0; pc_load_i = 0; pc_is_vector_i = 0; pc_target_i = 0;
    endtask

    // drive at negedge, design registers at posedge, sample at next negedge
    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        logic seen;
        idle();
        repeat (3) @(negedge clk);
        // R8 R7 reset state
        chk("R9 reset req", rst_req_o, 0);
        chk("R7 reset cause", cause_o, 0);
        chk("R8 reset flag", ill_flag_o, 0);
        rst_n = 1'b1;
        step();
        seen = 1'b0;
        for (int i = 0; i < NV; i++) begin
            fetch_valid_i = VECS[i].fv; fetch_op_hi_i = VECS[i].op;
            wr_en_i = VECS[i].we; wr_idx_i = VECS[i].widx;
            ptr_use_i = VECS[i].pu; ptr_idx_i = VECS[i].pidx;
            pc_load_i = VECS[i].pl; pc_is_vector_i = VECS[i].pv; pc_target_i = VECS[i].tgt;
            step();
            seen = seen | VECS[i].req;
            chk($sformatf("R%0d vec %0d req", VECS[i].rq, i), rst_req_o, VECS[i].req);
            chk($sformatf("R%0d vec %0d cause", VECS[i].rq, i), cause_o, VECS[i].cause);
            chk($sformatf("R8 vec %0d flag", i), ill_flag_o, seen);
        end
        idle();
        // R2: write r9, power-on reset, then r9 must be uninitialized again
        wr_en_i = 1; wr_idx_i = 4'd9;
        step();
        idle();
        step();
        chk("R8 flag held", ill_flag_o, 1);
        rst_n = 1'b0;
        step();
        chk("R8 flag cleared by reset", ill_flag_o, 0);
        chk("R7 cause cleared by reset", cause_o, 0);
        rst_n = 1'b1;
        step();
        ptr_use_i = 1; ptr_idx_i = 4'd9;
        step();
        idle();
        chk("R2 r9 uninit after reset req", rst_req_o, 1);
        chk("R2 r9 uninit after reset cause", cause_o, 2);
        step();
        chk("R9 single pulse", rst_req_o, 0);
        // R5 empty window: base above limit
        seg_base_i[31:16] = 16'h0500; seg_limit_i[31:16] = 16'h0400;
        pc_load_i = 1; pc_is_vector_i = 1; pc_target_i = 16'h0450;
        step();
        idle();
        chk("R5 empty window", rst_req_o, 0);
        // R6 vector into boot window off-slot
        pc_load_i = 1; pc_is_vector_i = 1; pc_target_i = 16'h0106;
        step();
        idle();
        chk("R6 vector boot req", rst_req_o, 1);
        chk("R6 vector boot cause", cause_o, 3);
        // R3: write then use next cycle
        wr_en_i = 1; wr_idx_i = 4'd2;
        step();
        idle();
        ptr_use_i = 1; ptr_idx_i = 4'd2;
        step();
        idle();
        chk("R3 written r2 legal", rst_req_o, 0);
        // R4: unwritten r14
        ptr_use_i = 1; ptr_idx_i = 4'd14;
        step();
        idle();
        chk("R4 r14 req", rst_req_o, 1);
        chk("R4 r14 cause", cause_o, 2);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule